// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a logical address onto a physical one through a small table of segments. A logical address is a segment number and an offset. The segment number picks one table slot, and each slot holds a base address, a length and three permission flags (read, write, execute). A lookup is accepted only if the slot is loaded, the access kind is allowed by the flags, and the offset falls inside the segment. An accepted lookup returns base plus offset. A rejected one raises a fault with a two-bit reason.

The answer comes one clock after the request. Supervisor software fills the table through a separate write port, and each write is visible to lookups from the following cycle on. A plain base/limit relocation scheme is the case of one loaded slot.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table slot is unloaded, and `out_valid`, `out_fault`, `out_cause` and `out_addr` are all zero.
- R2: A lookup that passes every check raises `out_valid` in the next cycle, with `out_addr` equal to base plus offset as a full 17-bit sum that never wraps.
- R3: An offset equal to or above the slot's limit is rejected with cause 2'b01. A slot with limit 0 rejects every offset this way.
- R4: The access kind is encoded as 00 = read, 01 = write, 10 = execute, and needs flag bit 2, 1 or 0 of the slot respectively. Kind 11 is never allowed. A refused access gets cause 2'b10.
- R5: A lookup on an unloaded slot gets cause 2'b11. A configuration write with `cfg_valid` low unloads the slot.
- R6: In the cycle after a request exactly one of `out_valid` and `out_fault` is high. In the cycle after a cycle with no request both are low.
- R7: When several checks fail, the cause reported is chosen in this order: unloaded first, then permission, then bounds.
- R8: A configuration write takes effect for lookups presented in the following cycle. A lookup in the same cycle as a write to its slot still sees the slot's old contents.
- R9: While `out_fault` is high, `out_addr` is zero. While `out_fault` is low, `out_cause` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 3 | Segment number of the logical address |
| req_off | input | 16 | Offset of the logical address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Slot to write |
| cfg_base | input | 16 | Segment base address |
| cfg_limit | input | 16 | Segment length |
| cfg_perm | input | 3 | Permission flags {read, write, execute} |
| cfg_valid | input | 1 | Loaded flag written into the slot |
| out_valid | output | 1 | Translation succeeded |
| out_addr | output | 17 | Physical address |
| out_fault | output | 1 | Translation rejected |
| out_cause | output | 2 | Reject reason: 01 bounds, 10 permission, 11 unloaded |

## Verification
A table write and a lookup can happen in the same cycle, and they can target the same slot. The bench presents both on one edge. It loads an empty slot and also re-flags a loaded one. In each case it checks that this lookup returns the slot's previous verdict and that a lookup on the next cycle returns the new one. Priority among failed checks is tested separately, using lookups that break two rules at once.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEGS = 8,
  parameter int AW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [$clog2(SEGS)-1:0] req_seg,
  input  logic [AW-1:0]           req_off,
  input  logic [1:0]              req_acc,
  input  logic                    cfg_we,
  input  logic [$clog2(SEGS)-1:0] cfg_idx,
  input  logic [AW-1:0]           cfg_base,
  input  logic [AW-1:0]           cfg_limit,
  input  logic [2:0]              cfg_perm,
  input  logic                    cfg_valid,
  output logic                    out_valid,
  output logic [AW:0]             out_addr,
  output logic                    out_fault,
  output logic [1:0]              out_cause
);
  localparam int PW = AW + 1;

  logic [AW-1:0] tbl_base [SEGS];
  logic [AW-1:0] tbl_lim  [SEGS];
  logic [2:0]    tbl_perm [SEGS];
  logic [SEGS-1:0] tbl_vld;

  logic          hit_vld;
  logic          perm_ok;
  logic          in_bounds;
  logic [1:0]    cause;
  logic [PW-1:0] sum;

  assign hit_vld   = tbl_vld[req_seg];
  assign in_bounds = req_off < tbl_lim[req_seg];
  assign sum       = {1'b0, tbl_base[req_seg]} + {1'b0, req_off};

  always_comb begin
    case (req_acc)
      2'b00:   perm_ok = tbl_perm[req_seg][2];
      2'b01:   perm_ok = tbl_perm[req_seg][1];
      2'b10:   perm_ok = tbl_perm[req_seg][0];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!hit_vld)        cause = 2'b11;
    else if (!perm_ok)   cause = 2'b10;
    else if (!in_bounds) cause = 2'b01;
    else                 cause = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_vld <= '0;
    end else if (cfg_we) begin
      tbl_vld[cfg_idx] <= cfg_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      tbl_base[cfg_idx] <= cfg_base;
      tbl_lim[cfg_idx]  <= cfg_limit;
      tbl_perm[cfg_idx] <= cfg_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_cause <= 2'b00;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid && (cause == 2'b00);
      out_fault <= req_valid && (cause != 2'b00);
      out_cause <= req_valid ? cause : 2'b00;
      out_addr  <= (req_valid && cause == 2'b00) ? sum : '0;
    end
  end

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_fault));

  p_req_answered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_valid || out_fault));

  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_fault));

  p_cause_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault == (out_cause != 2'b00));

  p_fault_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_addr == '0));

  p_bounds_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tbl_vld[req_seg] && req_off >= tbl_lim[req_seg]) |=> out_fault);

endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_seg;
  logic [15:0] req_off;
  logic [1:0]  req_acc;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_base;
  logic [15:0] cfg_limit;
  logic [2:0]  cfg_perm;
  logic        cfg_valid;
  logic        out_valid;
  logic [16:0] out_addr;
  logic        out_fault;
  logic [1:0]  out_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_perm(cfg_perm), .cfg_valid(cfg_valid),
    .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault), .out_cause(out_cause)
  );

  // {seg, offset, kind, expect_ok, expect_cause, expect_addr}
  localparam int NV = 14;
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 16'h00FF, 2'd0, 1'b1, 2'd0, 17'h010FF},
    {3'd0, 16'h0100, 2'd0, 1'b0, 2'd1, 17'h00000},
    {3'd0, 16'h0010, 2'd1, 1'b0, 2'd2, 17'h00000},
    {3'd0, 16'h0010, 2'd2, 1'b1, 2'd0, 17'h01010},
    {3'd1, 16'h3FFF, 2'd1, 1'b1, 2'd0, 17'h0BFFF},
    {3'd1, 16'h0000, 2'd2, 1'b0, 2'd2, 17'h00000},
    {3'd2, 16'h001F, 2'd0, 1'b1, 2'd0, 17'h1000F},
    {3'd3, 16'h0000, 2'd0, 1'b0, 2'd1, 17'h00000},
    {3'd4, 16'h0000, 2'd0, 1'b0, 2'd3, 17'h00000},
    {3'd6, 16'h0000, 2'd0, 1'b0, 2'd3, 17'h00000},
    {3'd0, 16'h0200, 2'd1, 1'b0, 2'd2, 17'h00000},
    {3'd5, 16'hFFFE, 2'd1, 1'b1, 2'd0, 17'h0FFFE},
    {3'd1, 16'h0000, 2'd3, 1'b0, 2'd2, 17'h00000},
    {3'd4, 16'hFFFF, 2'd1, 1'b0, 2'd3, 17'h00000}
  };

  task automatic check(input string tag, input logic ev, input logic [1:0] ec, input logic [16:0] ea);
    logic ef;
    ef = (ec != 2'b00);
    checks++;
    if (out_valid !== ev || out_fault !== ef || out_cause !== ec || out_addr !== ea) begin
      fails++;
      $display("FAIL %s: got valid=%0b fault=%0b cause=%0d addr=%h, expected valid=%0b fault=%0b cause=%0d addr=%h",
               tag, out_valid, out_fault, out_cause, out_addr, ev, ef, ec, ea);
    end
  endtask

  task automatic write_slot(input logic [2:0] i, input logic [15:0] b, input logic [15:0] l,
                            input logic [2:0] p, input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_base = b; cfg_limit = l; cfg_perm = p; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [2:0] s, input logic [15:0] o, input logic [1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0; req_acc = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_limit = '0; cfg_perm = '0; cfg_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 1'b0, 2'd0, 17'h0);
    rst_n = 1'b1;

    lookup(3'd0, 16'h0000, 2'd0);
    check("R1 slots unloaded after reset", 1'b0, 2'd3, 17'h0);

    write_slot(3'd0, 16'h1000, 16'h0100, 3'b101, 1'b1);
    write_slot(3'd1, 16'h8000, 16'h4000, 3'b110, 1'b1);
    write_slot(3'd2, 16'hFFF0, 16'h0020, 3'b100, 1'b1);
    write_slot(3'd3, 16'h2000, 16'h0000, 3'b111, 1'b1);
    write_slot(3'd4, 16'h4000, 16'hFFFF, 3'b111, 1'b1);
    write_slot(3'd4, 16'h4000, 16'hFFFF, 3'b111, 1'b0);
    write_slot(3'd5, 16'h0000, 16'hFFFF, 3'b010, 1'b1);

    for (int k = 0; k < NV; k++) begin
      logic [40:0] v;
      string tag;
      v = VEC[k];
      tag = v[19] ? "R2 translate" :
            (v[18:17] == 2'd1) ? "R3 bounds" :
            (v[18:17] == 2'd2) ? "R4/R7 permission" : "R5/R7 unloaded";
      lookup(v[40:38], v[37:22], v[21:20]);
      check(tag, v[19], v[18:17], v[16:0]);
    end

    @(negedge clk);
    check("R6 no outcome without request", 1'b0, 2'd0, 17'h0);

    // R8: write to unloaded slot 7 together with a lookup of slot 7
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd7; cfg_base = 16'h3000; cfg_limit = 16'h0010; cfg_perm = 3'b100; cfg_valid = 1'b1;
    req_valid = 1'b1; req_seg = 3'd7; req_off = 16'h0004; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 same-cycle lookup sees old unloaded slot", 1'b0, 2'd3, 17'h0);
    req_seg = 3'd7; req_off = 16'h0004; req_acc = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next-cycle lookup sees new slot", 1'b1, 2'd0, 17'h03004);

    // R8: re-flag slot 7 as write-only with a same-cycle read
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd7; cfg_base = 16'h3000; cfg_limit = 16'h0010; cfg_perm = 3'b010; cfg_valid = 1'b1;
    req_valid = 1'b1; req_seg = 3'd7; req_off = 16'h000F; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 same-cycle lookup keeps old flags", 1'b1, 2'd0, 17'h0300F);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 new flags refuse read", 1'b0, 2'd2, 17'h0);

    lookup(3'd7, 16'h0010, 2'd1);
    check("R3 offset equal to limit", 1'b0, 2'd1, 17'h0);

    lookup(3'd3, 16'hFFFF, 2'd2);
    check("R3 zero-length slot", 1'b0, 2'd1, 17'h0);

    write_slot(3'd1, 16'h8000, 16'h4000, 3'b110, 1'b0);
    lookup(3'd1, 16'h0000, 2'd0);
    check("R5 slot unloaded by write", 1'b0, 2'd3, 17'h0);

    @(negedge clk);
    check("R9 outputs clear after fault", 1'b0, 2'd0, 17'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule